// File: doc/BRIEF.md
# Lock-Aware Way Replacement Selector

This block chooses which way of an eight-way set gets evicted when a read or write misses, and it rules on requests to pin a line in place. Each requester owns a partition mask naming the ways it may use. The block reads the partition mask of the requester now being served and the lock bits of every way at the current index. From these it returns a victim way and an updated copy of the lock bits, which the surrounding cache controller writes back to its tag store.

Victims are taken in round-robin order from the ways that are both usable and unlocked. Two misconfigurations are caught and reported. The first is a lock request that would pin the last usable unlocked way: the request is dropped, but the access still completes. The second is a miss that finds every usable way pinned: the block forces out the lowest usable way and releases its lock. Each condition sets its own sticky flag, and each flag has its own interrupt enable.

Top module: `way_repl_sel`

## Requirements
- R1: The usable ways for a request are taken from `part_masks_i[r*NUM_WAYS +: NUM_WAYS]`, where r is `req_id_i`. When that field is all zeros, every way counts as usable.
- R2: While at least one usable unlocked way exists, the reported victim is always usable and unlocked.
- R3: The victim is the first usable unlocked way found by scanning upward from a rotating pointer and wrapping at the top. The pointer is 0 after reset, and each miss moves it to the way after the victim, modulo `NUM_WAYS`.
- R4: When every usable way is locked, a miss evicts the lowest-numbered usable way. That way's bit is cleared in `lock_bits_o`, and flag bit 1 of `err_flags_o` (no free way) is set.
- R5: A lock request that would leave no usable unlocked way is refused. No lock bit is set, `lock_ack_o` still pulses with `lock_granted_o` low, and flag bit 0 (lock refused) is set.
- R6: Any other lock request is granted. It sets bit `lock_way_i` in `lock_bits_o` and raises `lock_granted_o`. The target way may lie outside the requester's mask.
- R7: `victim_valid_o`, `lock_upd_o` and `lock_ack_o` are one-cycle pulses in the cycle after `miss_i` or `lock_req_i`, as applicable, with their data registered alongside.
- R8: Error flags are sticky until a one is written to the matching `err_clr_i` bit. A new event in the same cycle as the clear wins.
- R9: `irq_o` is the OR over both flags of the flag ANDed with its bit in `irq_en_i`.
- R10: After reset, all outputs are zero.
- R11: After any strobe, `lock_bits_o` equals `lock_bits_i`, minus the bit released by a forced eviction, plus the bit set by a granted lock. A miss and a lock request in the same cycle are both judged against the incoming lock bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_id_i | input | RQW | Requester being served |
| part_masks_i | input | NUM_REQ*NUM_WAYS | Partition mask per requester |
| lock_bits_i | input | NUM_WAYS | Lock bits of the ways at the index |
| miss_i | input | 1 | Miss strobe, asks for a victim |
| lock_req_i | input | 1 | Lock request strobe |
| lock_way_i | input | WW | Way to lock |
| irq_en_i | input | 2 | Interrupt enables (bit 0 refused lock, bit 1 no free way) |
| err_clr_i | input | 2 | Write-one-to-clear strobes for the flags |
| victim_valid_o | output | 1 | Victim result pulse |
| victim_way_o | output | WW | Chosen victim way |
| lock_upd_o | output | 1 | Lock bits update pulse |
| lock_bits_o | output | NUM_WAYS | New lock bits for the index |
| lock_ack_o | output | 1 | Lock request completed |
| lock_granted_o | output | 1 | Lock request took effect |
| err_flags_o | output | 2 | Sticky flags (bit 0 refused lock, bit 1 no free way) |
| irq_o | output | 1 | Interrupt |

## Verification
The bench targets four kinds of corner case:

- **Pointer wrap.** It drives partitions where the rotating pointer must wrap past the top way. A scan that does not wrap would return a way outside the free set, or a stale way.
- **Full lockdown.** It locks every usable way and then misses. A design that ignored locks would evict a pinned line. One that picked the wrong fallback would name some way other than the lowest usable one, or would leave its lock bit set.
- **Refused locks.** It sends lock requests against the last free way, including requests whose target lies outside the partition. A faulty guard would pin the final way, or would refuse a harmless lock.
- **Flags and strobes together.** It sets a flag and clears it in the same cycle, and it issues a miss and a lock together. Wrong priority there would lose a flag, or would merge the two lock-bit updates incorrectly.

// File: rtl/wrs_pkg.sv
`timescale 1ns/1ps
package wrs_pkg;
   // Positions of the two error conditions inside the flag vector.
   typedef enum int unsigned {
      FLG_LOCK_REFUSED = 0,
      FLG_NO_FREE      = 1
   } wrs_flag_e;

   localparam int unsigned WRS_NUM_FLAGS = 2;
endpackage

// File: rtl/wrs_avail_mux.sv
`timescale 1ns/1ps
module wrs_avail_mux #(
   parameter int unsigned NUM_WAYS       = 8,
   parameter int unsigned NUM_REQ        = 4,
   parameter bit          EMPTY_MASK_ALL = 1'b1,
   localparam int unsigned RQW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic [NUM_REQ*NUM_WAYS-1:0] masks_i,
   input  logic [RQW-1:0]              req_i,
   output logic [NUM_WAYS-1:0]         avail_o
);
   logic [NUM_WAYS-1:0] sel_w;

   always_comb begin
      sel_w = '0;
      for (int r = 0; r < int'(NUM_REQ); r++) begin
         if (int'(req_i) == r) sel_w = masks_i[r*NUM_WAYS +: NUM_WAYS];
      end
   end

   if (EMPTY_MASK_ALL) begin : g_empty_all
      assign avail_o = (sel_w == '0) ? '1 : sel_w;
   end else begin : g_empty_none
      assign avail_o = sel_w;
   end
endmodule

// File: rtl/wrs_rr_pick.sv
`timescale 1ns/1ps
module wrs_rr_pick #(
   parameter int unsigned NUM_WAYS = 8,
   localparam int unsigned WW = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0] mask_i,
   input  logic [WW-1:0]       start_i,
   output logic                any_o,
   output logic [WW-1:0]       pick_o
);
   always_comb begin
      int  idx;
      logic found;
      found  = 1'b0;
      pick_o = '0;
      for (int k = 0; k < int'(NUM_WAYS); k++) begin
         idx = int'(start_i) + k;
         if (idx >= int'(NUM_WAYS)) idx = idx - int'(NUM_WAYS);
         if (!found && mask_i[idx]) begin
            pick_o = WW'(idx);
            found  = 1'b1;
         end
      end
      any_o = found;
   end

   // R2: whatever is picked must be a member of the offered set
   always_comb begin
      if (!$isunknown(mask_i) && any_o) begin
         a_r2_pick_in_mask: assert (mask_i[pick_o]);
      end
   end
endmodule

// File: rtl/wrs_lock_guard.sv
`timescale 1ns/1ps
module wrs_lock_guard #(
   parameter int unsigned NUM_WAYS = 8,
   localparam int unsigned WW = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0] lock_bits_i,
   input  logic [NUM_WAYS-1:0] avail_i,
   input  logic [WW-1:0]       way_i,
   output logic                grant_o,
   output logic [NUM_WAYS-1:0] set_mask_o
);
   localparam logic [NUM_WAYS-1:0] WAY_LSB = NUM_WAYS'(1);

   logic [NUM_WAYS-1:0] target_w;
   logic [NUM_WAYS-1:0] remain_w;

   assign target_w   = WAY_LSB << way_i;
   // ways that would still be free for general use if the lock took effect
   assign remain_w   = avail_i & ~(lock_bits_i | target_w);
   assign grant_o    = (remain_w != '0);
   assign set_mask_o = grant_o ? target_w : '0;
endmodule

// File: rtl/wrs_err_flags.sv
`timescale 1ns/1ps
module wrs_err_flags #(
   parameter int unsigned NUM_FLAGS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] set_i,
   input  logic [NUM_FLAGS-1:0] clr_i,
   input  logic [NUM_FLAGS-1:0] en_i,
   output logic [NUM_FLAGS-1:0] flags_o,
   output logic                 irq_o
);
   logic [NUM_FLAGS-1:0] flags_q;

   for (genvar f = 0; f < int'(NUM_FLAGS); f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flags_q[f] <= 1'b0;
         else if (set_i[f])  flags_q[f] <= 1'b1;
         else if (clr_i[f])  flags_q[f] <= 1'b0;
      end

      // R8: a raised flag stays up until cleared
      a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
         flags_q[f] && !clr_i[f] |=> flags_q[f]);
      // R8: a new event is never lost to a simultaneous clear
      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[f] |=> flags_q[f]);
   end

   assign flags_o = flags_q;
   assign irq_o   = |(flags_q & en_i);
endmodule

// File: rtl/way_repl_sel.sv
`timescale 1ns/1ps
module way_repl_sel
   import wrs_pkg::*;
#(
   parameter int unsigned NUM_WAYS       = 8,
   parameter int unsigned NUM_REQ        = 4,
   parameter bit          EMPTY_MASK_ALL = 1'b1,
   localparam int unsigned WW  = $clog2(NUM_WAYS),
   localparam int unsigned RQW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
   localparam int unsigned NF  = WRS_NUM_FLAGS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [RQW-1:0]              req_id_i,
   input  logic [NUM_REQ*NUM_WAYS-1:0] part_masks_i,
   input  logic [NUM_WAYS-1:0]         lock_bits_i,
   input  logic                        miss_i,
   input  logic                        lock_req_i,
   input  logic [WW-1:0]               lock_way_i,
   input  logic [NF-1:0]               irq_en_i,
   input  logic [NF-1:0]               err_clr_i,
   output logic                        victim_valid_o,
   output logic [WW-1:0]               victim_way_o,
   output logic                        lock_upd_o,
   output logic [NUM_WAYS-1:0]         lock_bits_o,
   output logic                        lock_ack_o,
   output logic                        lock_granted_o,
   output logic [NF-1:0]               err_flags_o,
   output logic                        irq_o
);
   localparam logic [NUM_WAYS-1:0] WAY_LSB = NUM_WAYS'(1);
   localparam logic [WW-1:0]       LAST_WAY = WW'(NUM_WAYS - 1);

   if (NUM_WAYS < 2) begin : g_bad_ways
      $error("way_repl_sel: NUM_WAYS must be at least 2");
   end
   if (NUM_REQ < 1) begin : g_bad_req
      $error("way_repl_sel: NUM_REQ must be at least 1");
   end

   // ---------------- combinational decision ----------------
   logic [NUM_WAYS-1:0] avail_w, free_w, clr_mask_w, set_mask_w, new_lock_w;
   logic [WW-1:0]       ptr_q, rr_way_w, low_way_w, victim_w;
   logic                rr_any_w, low_any_w, grant_w, fallback_w;
   logic [NF-1:0]       flag_set_w;

   wrs_avail_mux #(
      .NUM_WAYS(NUM_WAYS), .NUM_REQ(NUM_REQ), .EMPTY_MASK_ALL(EMPTY_MASK_ALL)
   ) u_avail (
      .masks_i(part_masks_i), .req_i(req_id_i), .avail_o(avail_w)
   );

   assign free_w = avail_w & ~lock_bits_i;

   // rotating choice among usable unlocked ways
   wrs_rr_pick #(.NUM_WAYS(NUM_WAYS)) u_rr (
      .mask_i(free_w), .start_i(ptr_q), .any_o(rr_any_w), .pick_o(rr_way_w)
   );

   // lowest usable way, used when everything usable is pinned
   wrs_rr_pick #(.NUM_WAYS(NUM_WAYS)) u_low (
      .mask_i(avail_w), .start_i('0), .any_o(low_any_w), .pick_o(low_way_w)
   );

   wrs_lock_guard #(.NUM_WAYS(NUM_WAYS)) u_guard (
      .lock_bits_i(lock_bits_i), .avail_i(avail_w), .way_i(lock_way_i),
      .grant_o(grant_w), .set_mask_o(set_mask_w)
   );

   assign fallback_w = miss_i && !rr_any_w;
   assign victim_w   = rr_any_w ? rr_way_w : low_way_w;
   assign clr_mask_w = (fallback_w && low_any_w) ? (WAY_LSB << low_way_w) : '0;
   assign new_lock_w = (lock_bits_i & ~clr_mask_w)
                     | ((lock_req_i && grant_w) ? set_mask_w : '0);

   always_comb begin
      flag_set_w                   = '0;
      flag_set_w[FLG_LOCK_REFUSED] = lock_req_i && !grant_w;
      flag_set_w[FLG_NO_FREE]      = fallback_w;
   end

   // ---------------- registered results ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q          <= '0;
         victim_valid_o <= 1'b0;
         victim_way_o   <= '0;
         lock_upd_o     <= 1'b0;
         lock_bits_o    <= '0;
         lock_ack_o     <= 1'b0;
         lock_granted_o <= 1'b0;
      end else begin
         victim_valid_o <= miss_i;
         lock_upd_o     <= miss_i || lock_req_i;
         lock_ack_o     <= lock_req_i;
         lock_granted_o <= lock_req_i && grant_w;
         if (miss_i) begin
            victim_way_o <= victim_w;
            ptr_q        <= (victim_w == LAST_WAY) ? '0 : victim_w + WW'(1);
         end
         if (miss_i || lock_req_i) lock_bits_o <= new_lock_w;
      end
   end

   wrs_err_flags #(.NUM_FLAGS(NF)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(flag_set_w), .clr_i(err_clr_i),
      .en_i(irq_en_i), .flags_o(err_flags_o), .irq_o(irq_o)
   );

   // ---------------- properties ----------------
   // R7: result pulses only follow their strobes
   a_r7_victim_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid_o |-> $past(miss_i));
   a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      lock_ack_o |-> $past(lock_req_i));

   // R2: with a free way present the victim is one of them
   a_r2_victim_free: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid_o && ($past(free_w) != '0)
      |-> (($past(free_w) >> victim_way_o) & WAY_LSB) != '0);

   // R4: a forced eviction leaves the victim unlocked
   a_r4_fallback_unlock: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid_o && ($past(free_w) == '0) && ($past(avail_w) != '0)
      |-> ((lock_bits_o >> victim_way_o) & WAY_LSB) == '0);

   // R5: a refused lock adds no lock bit
   a_r5_refuse_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      lock_ack_o && !lock_granted_o
      |-> (lock_bits_o & ~$past(lock_bits_i)) == '0);

   // R6: a granted lock shows up in the written-back bits
   a_r6_grant_sets: assert property (@(posedge clk) disable iff (!rst_n)
      lock_granted_o |-> ((lock_bits_o >> $past(lock_way_i)) & WAY_LSB) != '0);
endmodule

// File: tb/way_repl_sel_tb.sv
`timescale 1ns/1ps
module way_repl_sel_tb;
   localparam int NW = 8;
   localparam int NR = 4;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [1:0]      req_id_i;
   logic [NR*NW-1:0] part_masks_i;
   logic [NW-1:0]   lock_bits_i;
   logic            miss_i, lock_req_i;
   logic [2:0]      lock_way_i;
   logic [1:0]      irq_en_i, err_clr_i;
   logic            victim_valid_o, lock_upd_o, lock_ack_o, lock_granted_o, irq_o;
   logic [2:0]      victim_way_o;
   logic [NW-1:0]   lock_bits_o;
   logic [1:0]      err_flags_o;

   always #2.5 clk = ~clk;

   way_repl_sel u_dut (
      .clk(clk), .rst_n(rst_n), .req_id_i(req_id_i), .part_masks_i(part_masks_i),
      .lock_bits_i(lock_bits_i), .miss_i(miss_i), .lock_req_i(lock_req_i),
      .lock_way_i(lock_way_i), .irq_en_i(irq_en_i), .err_clr_i(err_clr_i),
      .victim_valid_o(victim_valid_o), .victim_way_o(victim_way_o),
      .lock_upd_o(lock_upd_o), .lock_bits_o(lock_bits_o), .lock_ack_o(lock_ack_o),
      .lock_granted_o(lock_granted_o), .err_flags_o(err_flags_o), .irq_o(irq_o)
   );

   int         n_chk = 0;
   int         n_fail = 0;
   int         m_ptr = 0;
   logic [1:0] m_flags = '0;
   bit         done = 1'b0;

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [NW-1:0] f_avail(int req, logic [NR*NW-1:0] masks);
      logic [NW-1:0] m;
      m = masks[req*NW +: NW];
      return (m == '0) ? '1 : m;
   endfunction

   function automatic int f_first(logic [NW-1:0] m, int start);
      for (int k = 0; k < NW; k++) begin
         if (m[(start + k) % NW]) return (start + k) % NW;
      end
      return -1;
   endfunction

   task automatic do_op(int req, logic [NR*NW-1:0] masks, logic [NW-1:0] locks,
                        bit miss, bit lreq, int lway, logic [1:0] en, logic [1:0] clr);
      logic [NW-1:0] av, fr, clrm, setm, rem;
      logic [1:0]    setf, fl;
      int            vic;
      bit            fb, gr;
      req_id_i = 2'(req); part_masks_i = masks; lock_bits_i = locks;
      miss_i = miss; lock_req_i = lreq; lock_way_i = 3'(lway);
      irq_en_i = en; err_clr_i = clr;
      av = f_avail(req, masks);
      fr = av & ~locks;
      clrm = '0; setm = '0; fb = 1'b0; gr = 1'b0; vic = 0;
      if (miss) begin
         vic = f_first(fr, m_ptr);
         if (vic < 0) begin
            fb = 1'b1;
            vic = f_first(av, 0);
            clrm = NW'(1) << vic;
         end
      end
      if (lreq) begin
         rem = av & ~(locks | (NW'(1) << lway));
         gr = (rem != '0);
         if (gr) setm = NW'(1) << lway;
      end
      setf = {fb, lreq && !gr};
      fl = setf | (m_flags & ~clr);
      @(negedge clk);
      check("R7 victim_valid", int'(victim_valid_o), int'(miss));
      check("R7 lock_upd", int'(lock_upd_o), int'(miss | lreq));
      check("R5 lock_ack", int'(lock_ack_o), int'(lreq));
      check("R6 lock_granted", int'(lock_granted_o), int'(gr));
      if (miss) begin
         check(fb ? "R4 victim" : "R3 victim", int'(victim_way_o), vic);
         check("R1 victim usable", int'(av[victim_way_o]), 1);
         if (!fb) check("R2 victim unlocked", int'(locks[victim_way_o]), 0);
         m_ptr = (vic + 1) % NW;
      end
      if (miss || lreq)
         check(fb ? "R4 lock_bits" : (lreq && !gr) ? "R5 lock_bits" : "R11 lock_bits",
               int'(lock_bits_o), int'((locks & ~clrm) | setm));
      check("R8 flags", int'(err_flags_o), int'(fl));
      check("R9 irq", int'(irq_o), int'(|(fl & en)));
      m_flags = fl;
      miss_i = 1'b0; lock_req_i = 1'b0; err_clr_i = '0;
   endtask

   // requester 0 -> 0x03, 1 -> 0x30, 2 -> 0x0C, 3 -> empty (all ways)
   localparam logic [NR*NW-1:0] MD = {8'h00, 8'h0C, 8'h30, 8'h03};

   initial begin
      rst_n = 1'b0; req_id_i = '0; part_masks_i = '0; lock_bits_i = '0;
      miss_i = 1'b0; lock_req_i = 1'b0; lock_way_i = '0;
      irq_en_i = '0; err_clr_i = '0;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check("R10 victim_valid", int'(victim_valid_o), 0);
      check("R10 victim_way", int'(victim_way_o), 0);
      check("R10 lock_bits", int'(lock_bits_o), 0);
      check("R10 flags", int'(err_flags_o), 0);
      check("R10 irq", int'(irq_o), 0);
      check("R10 lock_ack", int'(lock_ack_o), 0);

      // R1 / R3: partition 0x30, pointer wrap 4 -> 5 -> 4
      do_op(1, MD, 8'h00, 1, 0, 0, 2'b00, 2'b00);
      do_op(1, MD, 8'h00, 1, 0, 0, 2'b00, 2'b00);
      do_op(1, MD, 8'h00, 1, 0, 0, 2'b00, 2'b00);
      // R1: empty mask means all ways; only way 6 free
      do_op(3, MD, 8'hBF, 1, 0, 0, 2'b00, 2'b00);
      // R4: all usable ways locked -> lowest usable (2), unlocked
      do_op(2, MD, 8'h0C, 1, 0, 0, 2'b11, 2'b00);
      // R5: locking last free way refused
      do_op(0, MD, 8'h02, 0, 1, 0, 2'b11, 2'b00);
      // R6: normal lock, and lock outside partition
      do_op(2, MD, 8'h00, 0, 1, 2, 2'b11, 2'b00);
      do_op(0, MD, 8'h00, 0, 1, 5, 2'b11, 2'b00);
      // R9: enables gate the interrupt
      do_op(0, MD, 8'h00, 0, 0, 0, 2'b01, 2'b00);
      do_op(0, MD, 8'h00, 0, 0, 0, 2'b00, 2'b00);
      // R8: clear both, then set and clear in the same cycle
      do_op(0, MD, 8'h00, 0, 0, 0, 2'b11, 2'b11);
      do_op(0, MD, 8'h02, 0, 1, 0, 2'b11, 2'b01);
      do_op(0, MD, 8'h00, 0, 0, 0, 2'b11, 2'b11);
      // R11: miss with fallback and a lock request together
      do_op(2, MD, 8'h0C, 1, 1, 3, 2'b10, 2'b00);
      do_op(2, MD, 8'h04, 1, 1, 3, 2'b10, 2'b11);

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         logic [NR*NW-1:0] mk;
         logic [NW-1:0]    lk;
         int               sel;
         mk  = {$urandom(), $urandom()} >> 0;
         mk  = NR*NW'($urandom()) & NR*NW'($urandom() | $urandom());
         sel = $urandom_range(0, 3);
         lk  = (sel == 0) ? NW'($urandom()) :
               (sel == 1) ? NW'($urandom() | $urandom()) :
               (sel == 2) ? 8'hFF : NW'($urandom() & $urandom());
         do_op($urandom_range(0, 3), mk, lk, $urandom_range(0, 1) == 1,
               $urandom_range(0, 2) == 0, $urandom_range(0, 7),
               2'($urandom()), ($urandom_range(0, 7) == 0) ? 2'($urandom()) : 2'b00);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         $display("FAIL R7 watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule